// File: doc/BRIEF.md
# Frame Sync Protector with Sync Insertion

This block sits after the channel-bit recovery and pattern matcher of an optical-disc read channel. It receives one strobe per recovered channel bit and a pulse that marks a bit on which the sync pattern was recognised. It keeps an internal frame position counter. A recognised sync is taken as a frame boundary only when it lands inside a protection window centred on the position where the next boundary is due. Recognised patterns outside the window are treated as noise and dropped. If the window closes without a sync, the block makes a boundary of its own, so the downstream frame logic never loses cadence.

A run of made-up boundaries of selectable length moves the block into an unlocked state. In that state the window is switched off and the next recognised sync is taken wherever it lands. A lock-status flag reports whether each boundary came from a sync exactly on the nominal position. A filtered lock output reflects that flag sampled once every sixteen frames, and it drops only after a run of bad samples. This output is meant for a spindle or mode controller that must not react to short defects.

Top module: `frame_sync_protector`

## Requirements
- R1: The frame position `s` counts bit strobes since the last frame boundary, with the strobe that carries a sync counted as position `s`. While locked, a sync is accepted only when `FRAME_LEN - W <= s <= FRAME_LEN + W`. An accepted sync gives `frameStb` high for one cycle in the cycle after its bit strobe, and makes that bit the new boundary (position 0). A sync outside the window changes nothing.
- R2: The half-width `W` is 3 bit periods when `winSel` is 0 and 7 when `winSel` is 1.
- R3: When position `FRAME_LEN + W` is reached without an accepted sync, a boundary is inserted. `frameStb` pulses in the same cycle relation as for an accepted sync, and the boundary is placed `W` bits back, so that consecutive insertions are exactly `FRAME_LEN` bit strobes apart.
- R4: `insLimSel` codes 00, 01, 10 and 11 select 2, 4, 8 and 13 consecutive insertions. `unlockFlag` rises together with the strobe of the last insertion in such a run. Any accepted sync restarts the run count.
- R5: While `unlockFlag` is high, the next sync is accepted at any position. `unlockFlag` falls together with that strobe, and windowed operation resumes from it.
- R6: `lockFlag` changes only together with a frame strobe. It is 1 when the strobe comes from a sync accepted at exactly `s = FRAME_LEN`, and 0 for an inserted boundary or an accepted sync off the nominal position.
- R7: `lockFlag` is sampled on every sixteenth frame strobe after reset. `lockFilt` is updated one cycle after the sampling strobe: it goes high on a high sample and goes low only after 8 consecutive low samples.
- R8: After reset, `frameStb`, `lockFlag` and `lockFilt` are 0, `unlockFlag` is 1 and the frame position is 0.
- R9: `syncSeen` is ignored in any cycle where `bitStb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitStb | input | 1 | One recovered channel bit in this cycle |
| syncSeen | input | 1 | Sync pattern recognised on this bit (qualified by bitStb) |
| winSel | input | 1 | Window half-width: 0 = 3 bits, 1 = 7 bits |
| insLimSel | input | 2 | Insertion run limit: 00=2, 01=4, 10=8, 11=13 |
| frameStb | output | 1 | One-cycle frame boundary pulse (accepted or inserted) |
| lockFlag | output | 1 | Last boundary came from an exactly aligned sync |
| unlockFlag | output | 1 | Protection released; next sync accepted anywhere |
| lockFilt | output | 1 | Debounced lock status |

## Verification
The assertions check structural invariants on every cycle. The frame position stays bounded. Every boundary pulse follows a bit strobe. The lock flag moves only with a boundary. The unlocked flag rises only on an inserted boundary and falls only on a boundary. The run counter stays below its largest limit. The filtered output changes only after a boundary. Where a boundary lands relative to the window edges for both widths, how long an insertion run lasts for each limit code, the unconditional catch while unlocked, and the 8-sample debounce can be shown only by the bench's scenarios. The bench compares every bit against a frame-level reference model.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  // Position status derived by the datapath for the current bit strobe
  typedef struct packed {
    logic bitTick;   // a channel bit arrives this cycle
    logic syncHit;   // sync pattern on this bit
    logic inWin;     // this bit lies inside the protection window
    logic onTime;    // this bit is exactly the nominal boundary position
    logic winEnd;    // window closes on this bit
  } posInfo_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic accept;    // take this bit as the frame boundary
    logic insert;    // make a boundary from the internal counter
    logic coincide;  // boundary matched the nominal position
  } frameCmd_t;

  // Insertion run limit for each select code
  function automatic logic [3:0] insLimit(input logic [1:0] sel);
    case (sel)
      2'b00:   insLimit = 4'd2;
      2'b01:   insLimit = 4'd4;
      2'b10:   insLimit = 4'd8;
      default: insLimit = 4'd13;
    endcase
  endfunction

endpackage

// File: rtl/fsp_datapath.sv
module fsp_datapath
  import fsp_pkg::*;
#(
  parameter int FRAME_LEN  = 588,
  parameter int WIN_NARROW = 3,
  parameter int WIN_WIDE   = 7
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitStb,
  input  logic      syncSeen,
  input  logic      winSel,
  input  frameCmd_t cmd,
  output posInfo_t  pos,
  output logic      frameStb,
  output logic      lockFlag
);

  localparam int PH_MAX = FRAME_LEN + WIN_WIDE;
  localparam int PH_W   = $clog2(PH_MAX + 2);
  localparam logic [PH_W-1:0] LEN_P    = PH_W'(FRAME_LEN);
  localparam logic [PH_W-1:0] NARROW_P = PH_W'(WIN_NARROW);
  localparam logic [PH_W-1:0] WIDE_P   = PH_W'(WIN_WIDE);

  logic [PH_W-1:0] phase;     // bit strobes since the last boundary
  logic [PH_W-1:0] phaseNext; // position of the bit arriving now
  logic [PH_W-1:0] winHalf;

  always_comb begin
    winHalf     = winSel ? WIDE_P : NARROW_P;
    phaseNext   = phase + 1'b1;
    pos.bitTick = bitStb;
    pos.syncHit = bitStb && syncSeen;
    pos.inWin   = (phaseNext >= LEN_P - winHalf) && (phaseNext <= LEN_P + winHalf);
    pos.onTime  = (phaseNext == LEN_P);
    pos.winEnd  = (phaseNext >= LEN_P + winHalf);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= '0;
      frameStb <= 1'b0;
      lockFlag <= 1'b0;
    end else begin
      frameStb <= cmd.accept || cmd.insert;
      if (cmd.accept || cmd.insert) begin
        lockFlag <= cmd.coincide;
      end
      if (bitStb) begin
        if (cmd.accept) begin
          phase <= '0;
        end else if (cmd.insert) begin
          phase <= winHalf;
        end else begin
          phase <= phaseNext;
        end
      end
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    phase <= PH_W'(PH_MAX)) else $error("phase out of range"); // R3

  AST_STROBE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    frameStb |-> $past(bitStb)) else $error("frame strobe without bit"); // R9

  AST_LOCK_MOVES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !frameStb |-> $stable(lockFlag)) else $error("lock flag moved off strobe"); // R6

endmodule

// File: rtl/fsp_control.sv
module fsp_control
  import fsp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  posInfo_t   pos,
  input  logic [1:0] insLimSel,
  output frameCmd_t  cmd,
  output logic       unlockFlag
);

  logic [3:0] insRun;      // consecutive insertions so far
  logic [3:0] insRunNext;

  always_comb begin
    cmd.accept   = pos.syncHit && (unlockFlag || pos.inWin);
    cmd.insert   = pos.bitTick && !cmd.accept && pos.winEnd;
    cmd.coincide = cmd.accept && pos.onTime;
    insRunNext   = insRun + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlockFlag <= 1'b1;
      insRun     <= '0;
    end else if (cmd.accept) begin
      unlockFlag <= 1'b0;
      insRun     <= '0;
    end else if (cmd.insert && !unlockFlag) begin
      if (insRunNext >= insLimit(insLimSel)) begin
        unlockFlag <= 1'b1;
        insRun     <= '0;
      end else begin
        insRun <= insRunNext;
      end
    end
  end

  AST_RUN_BELOW_MAX: assert property (@(posedge clk) disable iff (!rstN)
    insRun < 4'd13) else $error("insertion run overflow"); // R4

  AST_RUN_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    unlockFlag |-> insRun == 4'd0) else $error("run counting while unlocked"); // R5

endmodule

// File: rtl/fsp_lock_filter.sv
module fsp_lock_filter #(
  parameter int SAMPLE_DIV = 16,
  parameter int LOW_RUN    = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameStb,
  input  logic lockFlag,
  output logic lockFilt
);

  localparam int DIV_W = $clog2(SAMPLE_DIV);
  localparam int LOW_W = $clog2(LOW_RUN + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);
  localparam logic [LOW_W-1:0] LOW_FULL = LOW_W'(LOW_RUN);

  logic [DIV_W-1:0] divCnt;
  logic [LOW_W-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      lowCnt   <= '0;
      lockFilt <= 1'b0;
    end else if (frameStb) begin
      if (divCnt == DIV_LAST) begin
        divCnt <= '0;
        if (lockFlag) begin
          lockFilt <= 1'b1;
          lowCnt   <= '0;
        end else if (lowCnt != LOW_FULL) begin
          lowCnt <= lowCnt + 1'b1;
          if (lowCnt + 1'b1 == LOW_FULL) begin
            lockFilt <= 1'b0;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  AST_FILT_MOVES_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lockFilt) |-> $past(frameStb)) else $error("filter moved off strobe"); // R7

  AST_LOW_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= LOW_FULL) else $error("low run overflow"); // R7

endmodule

// File: rtl/frame_sync_protector.sv
module frame_sync_protector
  import fsp_pkg::*;
#(
  parameter int FRAME_LEN  = 588,
  parameter int WIN_NARROW = 3,
  parameter int WIN_WIDE   = 7,
  parameter int SAMPLE_DIV = 16,
  parameter int LOW_RUN    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitStb,
  input  logic       syncSeen,
  input  logic       winSel,
  input  logic [1:0] insLimSel,
  output logic       frameStb,
  output logic       lockFlag,
  output logic       unlockFlag,
  output logic       lockFilt
);

  posInfo_t  pos;
  frameCmd_t cmd;

  fsp_datapath #(
    .FRAME_LEN (FRAME_LEN),
    .WIN_NARROW(WIN_NARROW),
    .WIN_WIDE  (WIN_WIDE)
  ) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .bitStb  (bitStb),
    .syncSeen(syncSeen),
    .winSel  (winSel),
    .cmd     (cmd),
    .pos     (pos),
    .frameStb(frameStb),
    .lockFlag(lockFlag)
  );

  fsp_control uControl (
    .clk       (clk),
    .rstN      (rstN),
    .pos       (pos),
    .insLimSel (insLimSel),
    .cmd       (cmd),
    .unlockFlag(unlockFlag)
  );

  fsp_lock_filter #(
    .SAMPLE_DIV(SAMPLE_DIV),
    .LOW_RUN   (LOW_RUN)
  ) uFilter (
    .clk     (clk),
    .rstN    (rstN),
    .frameStb(frameStb),
    .lockFlag(lockFlag),
    .lockFilt(lockFilt)
  );

  AST_UNLOCK_RISES_ON_INSERT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlockFlag) |-> frameStb && !lockFlag) else $error("unlock without insertion"); // R4

  AST_UNLOCK_FALLS_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unlockFlag) |-> frameStb) else $error("relock without strobe"); // R5

endmodule

// File: tb/tb_frame_sync_protector.sv
module tb_frame_sync_protector;

  localparam int LEN = 48;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitStb = 1'b0;
  logic       syncSeen = 1'b0;
  logic       winSel = 1'b0;
  logic [1:0] insLimSel = 2'b00;
  logic       frameStb, lockFlag, unlockFlag, lockFilt;

  frame_sync_protector #(.FRAME_LEN(LEN)) dut (
    .clk(clk), .rstN(rstN), .bitStb(bitStb), .syncSeen(syncSeen),
    .winSel(winSel), .insLimSel(insLimSel), .frameStb(frameStb),
    .lockFlag(lockFlag), .unlockFlag(unlockFlag), .lockFilt(lockFilt)
  );

  always #2 clk = ~clk;  // 250 MHz

  int    nChecks = 0;
  int    nErrors = 0;
  string curTag  = "R8";

  // reference model state
  int mPh, mIns, mDiv, mLow;
  bit mUnl, mLock, mFrame, mFilt;

  function automatic int expLimit(input logic [1:0] sel);
    case (sel)
      2'b00: return 2;
      2'b01: return 4;
      2'b10: return 8;
      default: return 13;
    endcase
  endfunction

  function automatic int halfWin(input logic sel);
    return sel ? 7 : 3;
  endfunction

  task automatic chk(input string sig, input logic got, input logic exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %b expected %b", curTag, sig, got, exp);
    end
  endtask

  task automatic modelReset();
    mPh = 0; mIns = 0; mDiv = 0; mLow = 0;
    mUnl = 1; mLock = 0; mFrame = 0; mFilt = 0;
  endtask

  // one channel bit over two clocks; straySync drives syncSeen in the idle cycle
  task automatic stepBit(input bit sync, input bit straySync);
    int  w, s;
    bit  acc, ins;
    @(negedge clk);
    bitStb = 1'b1; syncSeen = sync;
    @(negedge clk);
    bitStb = 1'b0; syncSeen = straySync;
    w = halfWin(winSel);
    s = mPh + 1;
    acc = sync && (mUnl || (s >= LEN - w && s <= LEN + w));
    ins = !acc && (s >= LEN + w);
    if (acc) begin
      mPh = 0; mLock = (s == LEN); mUnl = 0; mIns = 0;
    end else if (ins) begin
      mPh = w; mLock = 0;
      if (!mUnl) begin
        if (mIns + 1 >= expLimit(insLimSel)) begin mUnl = 1; mIns = 0; end
        else mIns++;
      end
    end else begin
      mPh = s;
    end
    mFrame = acc || ins;
    chk("frameStb", frameStb, mFrame);
    chk("lockFlag", lockFlag, mLock);
    chk("unlockFlag", unlockFlag, mUnl);
    if (mFrame) begin
      if (mDiv == 15) begin
        mDiv = 0;
        if (mLock) begin mFilt = 1; mLow = 0; end
        else if (mLow < 8) begin
          mLow++;
          if (mLow == 8) mFilt = 0;
        end
      end else mDiv++;
    end
    @(negedge clk);
    syncSeen = 1'b0;
    chk("lockFilt", lockFilt, mFilt);
    chk("frameStb idle", frameStb, 1'b0);
  endtask

  // run bits until a boundary; sync offered at LEN+off, strays at given rate
  task automatic sendFrame(input int off, input int strayPct);
    for (int n = 0; n < 4 * LEN; n++) begin
      bit sync;
      sync = (mPh + 1 == LEN + off);
      if (!sync && strayPct > 0) sync = ($urandom_range(99) < strayPct);
      stepBit(sync, ($urandom_range(9) == 0));
      if (mFrame) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL R3 watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8 reset state
    curTag = "R8";
    chk("frameStb", frameStb, 1'b0);
    chk("lockFlag", lockFlag, 1'b0);
    chk("unlockFlag", unlockFlag, 1'b1);
    chk("lockFilt", lockFilt, 1'b0);

    // R9 sync without a bit strobe
    curTag = "R9";
    syncSeen = 1'b1;
    repeat (4) @(negedge clk);
    chk("frameStb", frameStb, 1'b0);
    chk("unlockFlag", unlockFlag, 1'b1);
    syncSeen = 1'b0;

    // R5 unconditional catch while unlocked (position 18)
    curTag = "R5";
    sendFrame(18 - LEN, 0);
    chk("catch frameStb", mFrame, 1'b1);
    chk("catch unlockFlag", unlockFlag, 1'b0);

    // R6 aligned syncs
    curTag = "R6";
    for (int i = 0; i < 20; i++) sendFrame(0, 0);
    chk("aligned lockFlag", lockFlag, 1'b1);

    // R1 R2 window edges, both widths
    curTag = "R1";
    winSel = 1'b0;
    sendFrame(-3, 0); chk("edge -3 lockFlag", lockFlag, 1'b0);
    sendFrame(3, 0);  chk("edge +3 unlockFlag", unlockFlag, 1'b0);
    sendFrame(0, 0);
    curTag = "R2";
    sendFrame(-4, 0); chk("outside -4 inserted at +3", mPh == 3, 1'b1);
    sendFrame(0, 0);
    sendFrame(5, 0);  // outside narrow window: inserted
    winSel = 1'b1;
    sendFrame(0, 0);
    sendFrame(-7, 0); chk("wide -7 accepted", mPh == 0, 1'b1);
    sendFrame(7, 0);
    sendFrame(-8, 0); chk("wide -8 inserted", mPh == 7, 1'b1);
    sendFrame(0, 0);

    // R3 R4 insertion runs for each limit code
    for (int c = 0; c < 4; c++) begin
      curTag = "R4";
      insLimSel = 2'(c);
      sendFrame(0, 0); sendFrame(0, 0);
      for (int k = 1; k <= expLimit(insLimSel); k++) begin
        curTag = "R3";
        sendFrame(999, 0);
        curTag = "R4";
        chk("run unlockFlag", unlockFlag, k == expLimit(insLimSel));
      end
      curTag = "R5";
      sendFrame(-20, 0);
      chk("relock unlockFlag", unlockFlag, 1'b0);
    end

    // R7 debounce of the lock output
    curTag = "R7";
    winSel = 1'b0;
    for (int i = 0; i < 48; i++) sendFrame(0, 0);
    chk("filt high", lockFilt, 1'b1);
    for (int i = 0; i < 16 * 7; i++) sendFrame(1, 0);
    chk("filt holds after 7 low", lockFilt, 1'b1);
    for (int i = 0; i < 16; i++) sendFrame(1, 0);
    chk("filt low after 8 low", lockFilt, 1'b0);
    for (int i = 0; i < 16; i++) sendFrame(0, 0);
    chk("filt back high", lockFilt, 1'b1);

    // constrained random mix
    curTag = "R1";
    for (int i = 0; i < 500; i++) begin
      int off;
      case ($urandom_range(5))
        0, 1:    off = 0;
        2:       off = int'($urandom_range(18)) - 9;
        3:       off = 999;
        default: off = int'($urandom_range(6)) - 3;
      endcase
      winSel    = $urandom_range(1);
      insLimSel = 2'($urandom_range(3));
      sendFrame(off, 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule